// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits between the two ports of a shared memory and watches both of them every cycle. When both ports are enabled and point at the same word, it pulls an active-low busy line toward one of them, and it blocks writes from that port. The port chosen is the one whose enable and address settled later. A second port that lands on a word already in use is therefore the one told to wait, while the port that was there first keeps working.

Each port has a small saturating age counter. The counter restarts whenever that port's enable or address changes, so the port with the smaller age is the later arrival. If both ages are equal, a fixed side is flagged; the default is the right port. Once a side is flagged it stays flagged for as long as the match lasts. A mode input sets the role of the block. As master, it generates busy itself. As slave, it drives its busy outputs inactive and gates writes with busy values supplied by an external master.

Top module: `busy_arbiter`

## Requirements
- R1: The comparison uses every address bit. Two enabled addresses that differ only in the most significant bit produce no busy.
- R2: While either port's enable is low, both busy outputs are high. Out of reset, with all inputs low, both busy outputs are high and both write-permit outputs are low.
- R3: When both ports are enabled on different addresses, both busy outputs are high.
- R4: In master mode, when both ports are enabled on equal addresses, exactly one busy output is low in that same cycle. It belongs to the port whose age is smaller. A port's age is the number of cycles since its enable or address last changed, saturating at 2^AGE_W-1.
- R5: The two busy outputs are never low together. On equal ages the right port is flagged (TIE_RIGHT=1).
- R6: Once a side is flagged, it stays flagged while both ports remain enabled on equal addresses and master mode holds. This applies even after both ages saturate and become equal.
- R7: In master mode a port's write-permit output equals write AND enable AND its own busy output. A flagged port's writes are dropped.
- R8: In slave mode both busy outputs are high. A port's write-permit output equals write AND enable AND that port's busy input (active low).
- R9: A change of enable alone, or of address alone, restarts that port's age. The port that made the change becomes the later arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1: generate busy internally; 0: slave, use busy inputs |
| left_en | input | 1 | Left port enable, active high |
| left_addr | input | ADDR_W | Left port address |
| left_wr | input | 1 | Left port write request |
| right_en | input | 1 | Right port enable, active high |
| right_addr | input | ADDR_W | Right port address |
| right_wr | input | 1 | Right port write request |
| left_busy_in_n | input | 1 | Slave mode busy for left port, active low |
| right_busy_in_n | input | 1 | Slave mode busy for right port, active low |
| left_busy_n | output | 1 | Busy toward left port, active low |
| right_busy_n | output | 1 | Busy toward right port, active low |
| left_wr_ok | output | 1 | Left write permitted to reach the array |
| right_wr_ok | output | 1 | Right write permitted to reach the array |

## Verification
The hardest case to reach is a long match. It must last until both age counters saturate to the same value, so that only the held flag, and not the tie rule, decides which port is busy. The bench gets there by enabling the left port a few cycles after the right on a shared address and then holding both steady for well past the saturation limit. The other cases come from an exhaustive sweep over all address pairs of a narrow configuration, with arrival offsets on both sides. Directed sequences then change only the enable or only the address of one port, to show that each change alone restarts that port's age.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;

   typedef enum logic [1:0] {
      FLAG_NONE  = 2'b00,
      FLAG_LEFT  = 2'b01,
      FLAG_RIGHT = 2'b10
   } flag_e;

endpackage

// File: rtl/bsa_age_tracker.sv
module bsa_age_tracker #(
   parameter int ADDR_W = 12,
   parameter int AGE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [AGE_W-1:0]  age
);

   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic              prev_en;
   logic [ADDR_W-1:0] prev_addr;
   logic [AGE_W-1:0]  age_q;
   logic [AGE_W-1:0]  age_inc;
   logic              changed;

   always_comb begin
      changed = (en != prev_en) || (addr != prev_addr);
      age_inc = (age_q == AGE_MAX) ? AGE_MAX : age_q + 1'b1;
      age     = changed ? '0 : age_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en   <= 1'b0;
         prev_addr <= '0;
         age_q     <= '0;
      end else begin
         prev_en   <= en;
         prev_addr <= addr;
         age_q     <= age;
      end
   end

endmodule

// File: rtl/bsa_match_detect.sv
module bsa_match_detect #(
   parameter int ADDR_W  = 12,
   parameter int SLICE_W = 4
) (
   input  logic              en_a,
   input  logic              en_b,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic              hit
);

   localparam int NSLICE = (ADDR_W + SLICE_W - 1) / SLICE_W;

   logic [ADDR_W-1:0] bit_eq;
   logic [NSLICE-1:0] slice_eq;

   assign bit_eq = ~(addr_a ^ addr_b);

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      localparam int LO = s * SLICE_W;
      localparam int HI = ((LO + SLICE_W) > ADDR_W) ? ADDR_W - 1 : LO + SLICE_W - 1;
      assign slice_eq[s] = &bit_eq[HI:LO];
   end

   assign hit = en_a && en_b && (&slice_eq);

endmodule

// File: rtl/bsa_arbiter_core.sv
module bsa_arbiter_core
   import busy_arb_pkg::*;
#(
   parameter int AGE_W     = 4,
   parameter bit TIE_RIGHT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_master,
   input  logic             hit,
   input  logic [AGE_W-1:0] age_l,
   input  logic [AGE_W-1:0] age_r,
   output flag_e            flag
);

   flag_e flag_q;
   flag_e tie_flag;
   flag_e fresh;

   if (TIE_RIGHT) begin : g_tie_r
      assign tie_flag = FLAG_RIGHT;
   end else begin : g_tie_l
      assign tie_flag = FLAG_LEFT;
   end

   always_comb begin
      if (age_l < age_r)       fresh = FLAG_LEFT;
      else if (age_r < age_l)  fresh = FLAG_RIGHT;
      else                     fresh = tie_flag;

      if (!(is_master && hit))      flag = FLAG_NONE;
      else if (flag_q != FLAG_NONE) flag = flag_q;
      else                          flag = fresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= FLAG_NONE;
      else        flag_q <= flag;
   end

endmodule

// File: rtl/bsa_write_gate.sv
module bsa_write_gate (
   input  logic is_master,
   input  logic en,
   input  logic wr,
   input  logic own_busy_n,
   input  logic ext_busy_n,
   output logic wr_ok
);

   logic eff_busy_n;

   assign eff_busy_n = is_master ? own_busy_n : ext_busy_n;
   assign wr_ok      = wr && en && eff_busy_n;

endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
   import busy_arb_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int AGE_W     = 4,
   parameter int SLICE_W   = 4,
   parameter bit TIE_RIGHT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_master,
   input  logic              left_en,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic              left_wr,
   input  logic              right_en,
   input  logic [ADDR_W-1:0] right_addr,
   input  logic              right_wr,
   input  logic              left_busy_in_n,
   input  logic              right_busy_in_n,
   output logic              left_busy_n,
   output logic              right_busy_n,
   output logic              left_wr_ok,
   output logic              right_wr_ok
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("busy_arbiter: ADDR_W must be at least 1");
   end
   if (AGE_W < 2) begin : g_bad_age
      $error("busy_arbiter: AGE_W must be at least 2");
   end
   if (SLICE_W < 1) begin : g_bad_slice
      $error("busy_arbiter: SLICE_W must be at least 1");
   end

   logic [AGE_W-1:0] age_l;
   logic [AGE_W-1:0] age_r;
   logic             hit;
   flag_e            flag;

   bsa_age_tracker #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_age_l (
      .clk(clk), .rst_n(rst_n), .en(left_en), .addr(left_addr), .age(age_l)
   );

   bsa_age_tracker #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_age_r (
      .clk(clk), .rst_n(rst_n), .en(right_en), .addr(right_addr), .age(age_r)
   );

   bsa_match_detect #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_match (
      .en_a(left_en), .en_b(right_en),
      .addr_a(left_addr), .addr_b(right_addr),
      .hit(hit)
   );

   bsa_arbiter_core #(.AGE_W(AGE_W), .TIE_RIGHT(TIE_RIGHT)) u_core (
      .clk(clk), .rst_n(rst_n), .is_master(is_master), .hit(hit),
      .age_l(age_l), .age_r(age_r), .flag(flag)
   );

   assign left_busy_n  = (flag != FLAG_LEFT);
   assign right_busy_n = (flag != FLAG_RIGHT);

   bsa_write_gate u_gate_l (
      .is_master(is_master), .en(left_en), .wr(left_wr),
      .own_busy_n(left_busy_n), .ext_busy_n(left_busy_in_n), .wr_ok(left_wr_ok)
   );

   bsa_write_gate u_gate_r (
      .is_master(is_master), .en(right_en), .wr(right_wr),
      .own_busy_n(right_busy_n), .ext_busy_n(right_busy_in_n), .wr_ok(right_wr_ok)
   );

endmodule

// File: rtl/busy_arbiter_chk.sv
module busy_arbiter_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              is_master,
   input logic              left_en,
   input logic [ADDR_W-1:0] left_addr,
   input logic              left_wr,
   input logic              right_en,
   input logic [ADDR_W-1:0] right_addr,
   input logic              right_wr,
   input logic              left_busy_in_n,
   input logic              right_busy_in_n,
   input logic              left_busy_n,
   input logic              right_busy_n,
   input logic              left_wr_ok,
   input logic              right_wr_ok
);

   logic seen_q;
   logic same;

   assign same = left_en && right_en && (left_addr == right_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   // R5
   no_dual_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!left_busy_n && !right_busy_n));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!left_en || !right_en) |-> (left_busy_n && right_busy_n));

   // R3
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (left_addr != right_addr) |-> (left_busy_n && right_busy_n));

   // R4
   one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && same) |-> (left_busy_n != right_busy_n));

   // R6
   hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && is_master && $past(is_master) && same && $past(same)
       && $past(!left_busy_n)) |-> !left_busy_n);

   // R6
   hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && is_master && $past(is_master) && same && $past(same)
       && $past(!right_busy_n)) |-> !right_busy_n);

   // R7
   left_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !left_busy_n) |-> !left_wr_ok);

   // R7
   right_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !right_busy_n) |-> !right_wr_ok);

   // R8
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> (left_busy_n && right_busy_n
                      && (left_wr_ok == (left_wr && left_en && left_busy_in_n))
                      && (right_wr_ok == (right_wr && right_en && right_busy_in_n))));

endmodule

bind busy_arbiter busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .is_master(is_master),
   .left_en(left_en), .left_addr(left_addr), .left_wr(left_wr),
   .right_en(right_en), .right_addr(right_addr), .right_wr(right_wr),
   .left_busy_in_n(left_busy_in_n), .right_busy_in_n(right_busy_in_n),
   .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
   .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok)
);

// File: tb/test_busy_arbiter.sv
module test_busy_arbiter;

   localparam int AW   = 4;
   localparam int GW   = 3;
   localparam int AMAX = (1 << GW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          is_master = 1'b1;
   logic          le = 1'b0, re = 1'b0, lw = 1'b0, rw = 1'b0;
   logic [AW-1:0] la = '0, ra = '0;
   logic          lbi = 1'b1, rbi = 1'b1;
   logic          lbn, rbn, lwok, rwok;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   int            mage_l = 0, mage_r = 0, mflag = 0;
   logic          pl_en = 1'b0, pr_en = 1'b0;
   logic [AW-1:0] pl_addr = '0, pr_addr = '0;

   always #10 clk = ~clk;

   busy_arbiter #(.ADDR_W(AW), .AGE_W(GW), .SLICE_W(3), .TIE_RIGHT(1'b1)) i_busy_arbiter (
      .clk(clk), .rst_n(rst_n), .is_master(is_master),
      .left_en(le), .left_addr(la), .left_wr(lw),
      .right_en(re), .right_addr(ra), .right_wr(rw),
      .left_busy_in_n(lbi), .right_busy_in_n(rbi),
      .left_busy_n(lbn), .right_busy_n(rbn),
      .left_wr_ok(lwok), .right_wr_ok(rwok)
   );

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b (la=%0d ra=%0d le=%b re=%b)",
                  tag, what, act, exp, la, ra, le, re);
      end
   endtask

   task automatic drive(input logic l_en, input logic [AW-1:0] l_ad, input logic l_wr,
                        input logic r_en, input logic [AW-1:0] r_ad, input logic r_wr);
      @(posedge clk);
      #1;
      le = l_en; la = l_ad; lw = l_wr;
      re = r_en; ra = r_ad; rw = r_wr;
   endtask

   // compute expected outputs for the current cycle from the requirements and compare
   task automatic eval_check(input string force_tag);
      bit    chg_l, chg_r, hit;
      int    nf;
      string tag;
      logic  e_lb, e_rb, e_lw, e_rw;
      chg_l = (le != pl_en) || (la != pl_addr);
      chg_r = (re != pr_en) || (ra != pr_addr);
      mage_l = chg_l ? 0 : ((mage_l < AMAX) ? mage_l + 1 : AMAX);
      mage_r = chg_r ? 0 : ((mage_r < AMAX) ? mage_r + 1 : AMAX);
      pl_en = le; pl_addr = la; pr_en = re; pr_addr = ra;
      hit = is_master && le && re && (la == ra);
      if (!is_master)                           tag = "R8";
      else if (!(le && re))                     tag = "R2";
      else if ((la ^ ra) == (1 << (AW - 1)))    tag = "R1";
      else if (la != ra)                        tag = "R3";
      else if (mflag == 0 && mage_l == mage_r)  tag = "R5";
      else                                      tag = "R4";
      if (force_tag != "") tag = force_tag;
      if (!hit)                 nf = 0;
      else if (mflag != 0)      nf = mflag;
      else if (mage_l < mage_r) nf = 1;
      else if (mage_r < mage_l) nf = 2;
      else                      nf = 2;
      mflag = nf;
      e_lb = (nf != 1);
      e_rb = (nf != 2);
      e_lw = lw && le && (is_master ? e_lb : lbi);
      e_rw = rw && re && (is_master ? e_rb : rbi);
      @(negedge clk);
      check(tag, "left_busy_n", lbn, e_lb);
      check(tag, "right_busy_n", rbn, e_rb);
      check("R5", "not both busy", !(!lbn && !rbn), 1'b1);
      check(is_master ? "R7" : "R8", "left_wr_ok", lwok, e_lw);
      check(is_master ? "R7" : "R8", "right_wr_ok", rwok, e_rw);
   endtask

   task automatic step(input logic l_en, input logic [AW-1:0] l_ad, input logic l_wr,
                       input logic r_en, input logic [AW-1:0] r_ad, input logic r_wr,
                       input string tag);
      drive(l_en, l_ad, l_wr, r_en, r_ad, r_wr);
      eval_check(tag);
   endtask

   initial begin
      #4000000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // reset state, R2
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2", "reset left_busy_n", lbn, 1'b1);
      check("R2", "reset right_busy_n", rbn, 1'b1);
      check("R2", "reset left_wr_ok", lwok, 1'b0);
      check("R2", "reset right_wr_ok", rwok, 1'b0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      eval_check("R2");

      // exhaustive master sweep: all address pairs, arrival offsets -2..2
      for (int a = 0; a < (1 << AW); a++) begin
         for (int b = 0; b < (1 << AW); b++) begin
            for (int off = -2; off <= 2; off++) begin
               int ls, rs;
               ls = (off < 0) ? -off : 0;
               rs = (off > 0) ? off : 0;
               step(1'b0, AW'(a), 1'b0, 1'b0, AW'(b), 1'b0, "");
               for (int k = 0; k < 6; k++) begin
                  step(k >= ls, AW'(a), (k % 2) == 0, k >= rs, AW'(b), (k % 3) != 0, "");
               end
            end
         end
      end

      // R6: left arrives later, hold past age saturation
      step(1'b0, 4'd5, 1'b0, 1'b0, 4'd5, 1'b0, "R6");
      step(1'b0, 4'd5, 1'b0, 1'b1, 4'd5, 1'b1, "R6");
      step(1'b0, 4'd5, 1'b0, 1'b1, 4'd5, 1'b1, "R6");
      step(1'b1, 4'd5, 1'b1, 1'b1, 4'd5, 1'b1, "R6");
      for (int k = 0; k < 3 * AMAX; k++) begin
         step(1'b1, 4'd5, 1'b1, 1'b1, 4'd5, k[0], "R6");
      end
      check("R6", "left held after saturation", lbn, 1'b0);
      check("R6", "right free after saturation", rbn, 1'b1);

      // R9: address-only change on right, then enable-only change on left
      step(1'b1, 4'd3, 1'b0, 1'b1, 4'd9, 1'b0, "R9");
      for (int k = 0; k < 4; k++) step(1'b1, 4'd3, 1'b0, 1'b1, 4'd9, 1'b0, "R9");
      step(1'b1, 4'd3, 1'b1, 1'b1, 4'd3, 1'b1, "R9");
      check("R9", "right later by address", rbn, 1'b0);
      step(1'b1, 4'd3, 1'b1, 1'b1, 4'd3, 1'b1, "R9");
      step(1'b0, 4'd3, 1'b1, 1'b1, 4'd3, 1'b1, "R9");
      step(1'b0, 4'd3, 1'b1, 1'b1, 4'd3, 1'b1, "R9");
      step(1'b1, 4'd3, 1'b1, 1'b1, 4'd3, 1'b1, "R9");
      check("R9", "left later by enable", lbn, 1'b0);
      check("R9", "right free after left re-enable", rbn, 1'b1);

      // R8: slave sweep over busy inputs, matching and differing addresses
      is_master = 1'b0;
      for (int a = 0; a < 4; a++) begin
         for (int v = 0; v < 16; v++) begin
            lbi = v[0]; rbi = v[1];
            step(v[2], AW'(a), 1'b1, v[3], AW'(a ^ (v % 2)), 1'b1, "R8");
         end
      end
      lbi = 1'b1; rbi = 1'b1;
      is_master = 1'b1;
      step(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, "R2");
      step(1'b1, 4'd7, 1'b1, 1'b1, 4'd7, 1'b1, "R5");
      check("R5", "tie flags right", rbn, 1'b0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule